// File: doc/BRIEF.md
# Multi-Channel Timer Output Controller

This block turns compare-match strobes from four timer subchannels, plus two counter-reached-zero strobes, into four timer output pins. Each channel holds one logical state bit, active or inactive. A per-channel mode selects which strobes set, clear or invert that bit. A polarity bit maps the state onto the pin. A force bit can pin the output to a fixed level instead.

A 16-bit control word holds four 4-bit channel fields, and the block keeps that word itself. Software-side logic can write all 16 bits at once, either byte on its own, or a single bit. The current word is shown on `cfg_q`. Strobes are single-cycle pulses. A strobe seen at a rising edge changes the pin right after that edge.

Top module: `tmo_out_ctrl`

## Requirements
- R1: After a reset the control word is 0x0000, every channel state is inactive, and every pin is low.
- R2: Channel n (n = 1..4) owns control bits [4n-1:4n-4]. From high to low these are force enable, polarity, mode[1] and mode[0]. When force is 0, the pin equals the state XOR the polarity bit: polarity 0 means active-high and polarity 1 means active-low. Channel n drives pin bit n-1 and listens to match bit n-1.
- R3: While force is 1, the pin equals the polarity bit, whatever strobes arrive. The state bit still follows its strobes, and the pin shows that state as soon as force is cleared.
- R4: In mode 00 a match of the channel's own subchannel inverts its state.
- R5: In mode 01 an own match makes the state active, and a counter-0 zero strobe makes it inactive.
- R6: In mode 10 an own match makes the state active, and a counter-1 zero strobe makes it inactive. A counter-0 zero strobe has no effect in this mode.
- R7: In mode 11 an own match makes the state active, and a match of the next channel makes it inactive. Channel 4 treats channel 1 as its next channel.
- R8: When a set or invert event and a clear event reach one channel in the same cycle, the set or invert event takes effect.
- R9: `cfg_be[1]` loads bits [15:8] and `cfg_be[0]` loads bits [7:0] from `cfg_wdata`. A byte whose enable is low keeps its value.
- R10: With `cfg_bit_wr` high, bit `cfg_bit_idx` of the control word takes the value `cfg_bit_val`. If a byte write in the same cycle covers the same bit, the single-bit write wins for that bit.
- R11: A strobe sampled at a rising edge changes the pin right after that edge, and not before it. A control write takes effect after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wdata | input | 16 | Write data for the control word |
| cfg_be | input | 2 | Byte-lane write enables |
| cfg_bit_wr | input | 1 | Single-bit write strobe |
| cfg_bit_idx | input | 4 | Index of the bit to write |
| cfg_bit_val | input | 1 | Value for the single-bit write |
| match_stb | input | 4 | Per-subchannel compare-match strobes |
| cnt0_zero | input | 1 | Counter 0 reached zero |
| cnt1_zero | input | 1 | Counter 1 reached zero |
| cfg_q | output | 16 | Current control word |
| pin_o | output | 4 | Timer output pins |

## Verification
A bad channel state stays hidden until force is off, and then it shows on the pin the cycle after the strobe that should have set it. Because the state is a single bit, one wrong set, clear or invert keeps the pin at the wrong level until the next event on that channel. The bench therefore checks every pin right after each strobe cycle. It also releases force after events that arrived while force was on, so that state which was silently updated, or wrongly frozen, comes out on the pins. Errors in the chain wrap, the same-cycle priority and the mode 10 counter selection each show as one pin bit that differs on the cycle after the strobe.

// File: rtl/tmo_pkg.sv
// Package: shared types for the timer output controller.
// Assumes each channel field is four bits wide, with the force enable in its
// top bit and the 2-bit mode in its bottom two bits.
package tmo_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_CZ0    = 2'b01,
        MODE_CZ1    = 2'b10,
        MODE_CHAIN  = 2'b11
    } tmo_mode_e;

    typedef struct packed {
        logic      force_en;
        logic      low_act;
        tmo_mode_e mode;
    } tmo_field_t;

endpackage

// File: rtl/tmo_cfg_reg.sv
// Module: control word register with byte-lane and single-bit writes.
// Assumes REG_W is a multiple of 8. A single-bit write is applied after the
// byte lanes, so it wins for the bit it names.
module tmo_cfg_reg #(
    parameter int REG_W = 16,
    localparam int LANES = REG_W / 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] wdata,
    input  logic [LANES-1:0] be,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [REG_W-1:0] q
);

    logic [REG_W-1:0] nxt;

    // Merge the byte lanes first, then the single-bit write.
    always_comb begin
        nxt = q;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) nxt[i*8 +: 8] = wdata[i*8 +: 8];
        end
        if (bit_wr) nxt[bit_idx] = bit_val;
    end

    // Hold the control word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/tmo_chan.sv
// Module: one output channel. It decodes strobes into set, clear and invert
// events according to its mode, holds the logical state bit, and maps that
// state to the pin. Assumes strobes are single-cycle pulses. Invert and set
// take priority over clear.
module tmo_chan
    import tmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tmo_field_t fld,
    input  logic       own_match,
    input  logic       next_match,
    input  logic       zero0,
    input  logic       zero1,
    output logic       pin
);

    logic ev_set, ev_clr, ev_inv, state;

    // Decode the mode into event strobes.
    always_comb begin
        ev_set = 1'b0;
        ev_clr = 1'b0;
        ev_inv = 1'b0;
        unique case (fld.mode)
            MODE_TOGGLE: ev_inv = own_match;
            MODE_CZ0: begin
                ev_set = own_match;
                ev_clr = zero0;
            end
            MODE_CZ1: begin
                ev_set = own_match;
                ev_clr = zero1;
            end
            MODE_CHAIN: begin
                ev_set = own_match;
                ev_clr = next_match;
            end
            default: ;
        endcase
    end

    // State bit: invert, then set, then clear, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= 1'b0;
        else if (ev_inv) state <= ~state;
        else if (ev_set) state <= 1'b1;
        else if (ev_clr) state <= 1'b0;
    end

    // Map the state to the pin, or drive the forced level.
    always_comb begin
        if (fld.force_en) pin = fld.low_act;
        else              pin = state ^ fld.low_act;
    end

endmodule

// File: rtl/tmo_out_ctrl.sv
// Module: top of the multi-channel timer output controller. It holds the
// control word and builds one channel per output. Channel k (0-based)
// treats channel (k+1) mod NUM_CH as its successor in chain mode.
module tmo_out_ctrl
    import tmo_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int REG_W = NUM_CH * FIELD_W,
    localparam int LANES = REG_W / 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [LANES-1:0]  cfg_be,
    input  logic              cfg_bit_wr,
    input  logic [IDX_W-1:0]  cfg_bit_idx,
    input  logic              cfg_bit_val,
    input  logic [NUM_CH-1:0] match_stb,
    input  logic              cnt0_zero,
    input  logic              cnt1_zero,
    output logic [REG_W-1:0]  cfg_q,
    output logic [NUM_CH-1:0] pin_o
);

    tmo_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (cfg_wdata),
        .be      (cfg_be),
        .bit_wr  (cfg_bit_wr),
        .bit_idx (cfg_bit_idx),
        .bit_val (cfg_bit_val),
        .q       (cfg_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int NXT = (g + 1) % NUM_CH;
        tmo_field_t fld;
        assign fld = tmo_field_t'(cfg_q[g*FIELD_W +: FIELD_W]);
        tmo_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .fld        (fld),
            .own_match  (match_stb[g]),
            .next_match (match_stb[NXT]),
            .zero0      (cnt0_zero),
            .zero1      (cnt1_zero),
            .pin        (pin_o[g])
        );
    end

endmodule

// File: rtl/tmo_out_ctrl_chk.sv
// Module: assertion checker for tmo_out_ctrl, attached to it by bind.
// Assumes a synchronous active-low reset and single-cycle strobes.
module tmo_out_ctrl_chk #(
    parameter int NUM_CH = 4,
    localparam int REG_W = NUM_CH * 4,
    localparam int LANES = REG_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LANES-1:0]  cfg_be,
    input logic              cfg_bit_wr,
    input logic [NUM_CH-1:0] match_stb,
    input logic              cnt1_zero,
    input logic [REG_W-1:0]  cfg_q,
    input logic [NUM_CH-1:0] pin_o
);

    logic any_wr;
    assign any_wr = (|cfg_be) || cfg_bit_wr;

    // R1: all pins are low on the first cycle after reset is released.
    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_o == '0 && cfg_q == '0));

    // R9: with no write, the control word keeps its value.
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> $stable(cfg_q));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        logic frc, lact;
        logic [1:0] md;
        assign frc  = cfg_q[g*4+3];
        assign lact = cfg_q[g*4+2];
        assign md   = cfg_q[g*4 +: 2];

        // R3: a forced pin shows the polarity bit.
        a_r3_forced_level: assert property (@(posedge clk) disable iff (!rst_n)
            frc |-> (pin_o[g] == lact));

        // R4: an own match in mode 00 inverts the pin.
        a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc && md == 2'b00 && match_stb[g] && !any_wr)
            |=> (pin_o[g] != $past(pin_o[g])));

        // R8: an own match in a set mode drives the pin active, even with a clear.
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc && md != 2'b00 && match_stb[g] && !any_wr)
            |=> (pin_o[g] == !lact));

        // R6: in mode 10 only a counter-1 zero or an own match moves the pin.
        a_r6_cz0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!frc && md == 2'b10 && !match_stb[g] && !cnt1_zero && !any_wr)
            |=> $stable(pin_o[g]));
    end

endmodule

bind tmo_out_ctrl tmo_out_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_be     (cfg_be),
    .cfg_bit_wr (cfg_bit_wr),
    .match_stb  (match_stb),
    .cnt1_zero  (cnt1_zero),
    .cfg_q      (cfg_q),
    .pin_o      (pin_o)
);

// File: tb/tmo_out_ctrl_bench.sv
// Bench: a vector table walked by one loop, then directed tests.
module tmo_out_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  cfg_be = '0;
    logic        cfg_bit_wr = 1'b0;
    logic [3:0]  cfg_bit_idx = '0;
    logic        cfg_bit_val = 1'b0;
    logic [3:0]  match_stb = '0;
    logic        cnt0_zero = 1'b0;
    logic        cnt1_zero = 1'b0;
    logic [15:0] cfg_q;
    logic [3:0]  pin_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tmo_out_ctrl u_tmo_out_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wdata   (cfg_wdata),
        .cfg_be      (cfg_be),
        .cfg_bit_wr  (cfg_bit_wr),
        .cfg_bit_idx (cfg_bit_idx),
        .cfg_bit_val (cfg_bit_val),
        .match_stb   (match_stb),
        .cnt0_zero   (cnt0_zero),
        .cnt1_zero   (cnt1_zero),
        .cfg_q       (cfg_q),
        .pin_o       (pin_o)
    );

    // Vector: {cfg[15:0], match[3:0], z0, z1, expected pin[3:0]}
    localparam logic [25:0] VEC [0:16] = '{
        {16'h0000, 4'b0001, 1'b0, 1'b0, 4'b0001},  // R4
        {16'h0000, 4'b0011, 1'b0, 1'b0, 4'b0010},  // R4
        {16'h4444, 4'b0000, 1'b0, 1'b0, 4'b1101},  // R2
        {16'h1111, 4'b0000, 1'b1, 1'b0, 4'b0000},  // R5
        {16'h1111, 4'b0101, 1'b0, 1'b0, 4'b0101},  // R5
        {16'h1111, 4'b0010, 1'b1, 1'b0, 4'b0010},  // R8
        {16'h2222, 4'b0000, 1'b1, 1'b0, 4'b0010},  // R6
        {16'h2222, 4'b1000, 1'b0, 1'b1, 4'b1000},  // R6
        {16'h3333, 4'b0001, 1'b0, 1'b0, 4'b0001},  // R7
        {16'h3333, 4'b0010, 1'b0, 1'b0, 4'b0010},  // R7
        {16'h3333, 4'b1000, 1'b0, 1'b0, 4'b1010},  // R7
        {16'h3333, 4'b1111, 1'b0, 1'b0, 4'b1111},  // R8
        {16'hC8C8, 4'b0000, 1'b0, 1'b0, 4'b1010},  // R3
        {16'hC8C8, 4'b1111, 1'b0, 1'b0, 4'b1010},  // R3
        {16'h0000, 4'b0000, 1'b0, 1'b0, 4'b0000},  // R3
        {16'h3000, 4'b0001, 1'b0, 1'b0, 4'b0001},  // R7
        {16'h3000, 4'b1001, 1'b0, 1'b0, 4'b1000}   // R8
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [15:0] d, input logic [1:0] be);
        cfg_wdata = d;
        cfg_be    = be;
        @(negedge clk);
        cfg_be    = '0;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pins", {12'h0, pin_o}, 16'h0);
        check("R1 reset cfg", cfg_q, 16'h0);

        for (int i = 0; i < 17; i++) begin
            wr_word(VEC[i][25:10], 2'b11);
            match_stb = VEC[i][9:6];
            cnt0_zero = VEC[i][5];
            cnt1_zero = VEC[i][4];
            @(negedge clk);
            match_stb = '0;
            cnt0_zero = 1'b0;
            cnt1_zero = 1'b0;
            check($sformatf("R2/R4-R8 vector %0d", i), {12'h0, pin_o}, {12'h0, VEC[i][3:0]});
        end

        // R9: upper byte alone, then lower byte alone.
        wr_word(16'hABCD, 2'b10);
        check("R9 upper lane", cfg_q, 16'hAB00);
        wr_word(16'h1234, 2'b01);
        check("R9 lower lane", cfg_q, 16'hAB34);

        // R10: single-bit write, then a bit write that clashes with a byte write.
        cfg_bit_wr = 1'b1; cfg_bit_idx = 4'd3; cfg_bit_val = 1'b1;
        @(negedge clk);
        cfg_bit_wr = 1'b0;
        check("R10 bit write", cfg_q, 16'hAB3C);
        cfg_bit_wr = 1'b1; cfg_bit_idx = 4'd0; cfg_bit_val = 1'b0;
        wr_word(16'h00FF, 2'b01);
        cfg_bit_wr = 1'b0;
        check("R10 bit beats byte", cfg_q, 16'hABFE);

        // R11: the pin holds until the edge that samples the strobe.
        wr_word(16'h0000, 2'b11);
        check("R11 before strobe", {12'h0, pin_o}, 16'h0008);
        match_stb = 4'b0001;
        #1;
        check("R11 strobe not yet sampled", {12'h0, pin_o}, 16'h0008);
        @(negedge clk);
        match_stb = '0;
        check("R11 after edge", {12'h0, pin_o}, 16'h0009);

        // R1: a reset in mid-run clears the state and the control word.
        wr_word(16'h4444, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset pins", {12'h0, pin_o}, 16'h0);
        check("R1 mid-run reset cfg", cfg_q, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule